// File: doc/BRIEF.md
# Receive Address Exact and Hash Filter

This block sits beside a receive MAC and decides whether a frame whose destination address has already been extracted should be kept. Each lookup presents a 48-bit destination address. The block first compares it against sixteen programmable exact-match slots. If no valid slot matches and the address is a group (multicast) address, a 12-bit index cut from the upper address bits selects one bit of a 4096-bit hash table, and that bit decides. The all-ones broadcast address is always kept. Slot 0 is meant for the station's own unicast address. The other slots hold further addresses that must match exactly.

Software programs the slots, the table words and a two-bit window selector through a single-cycle register-write port. The selector chooses which 12 bits of the address form the hash index. The address is taken with byte 0 as its least significant byte (bits 7:0), so bit 0 of the address is the group bit. Each lookup returns a one-cycle result pulse exactly two clock cycles after it is issued.

Top module: `rx_addr_filter`

## Requirements
- R1: After reset, no result is pending, every exact slot is invalid, every table bit is 0 and the window selector is 0. Only broadcast is accepted in this state.
- R2: A write with `wrSel`=0 addresses the slot registers. Slot n owns index 2n (low word: address bytes 0..3, byte 0 in bits 7:0) and index 2n+1 (high word: bytes 4 and 5 in bits 15:0, slot-valid flag in bit 31, bits 30:16 ignored). Indices at or above 32 have no effect.
- R3: A lookup is accepted when any valid slot holds all 48 bits of the address. An address that differs from a slot in any single bit does not match that slot.
- R4: A slot whose valid flag is 0 takes no part in matching, whatever it holds. Writing a high word with bit 31 clear disables the slot.
- R5: The window selector is written with `wrSel`=2 and is taken from `wrData[1:0]`. Selector value 0 takes the hash index from address bits 47:36, value 1 from 46:35, value 2 from 45:34 and value 3 from 43:32.
- R6: The table has 128 words of 32 bits, each written with `wrSel`=1 at index `wrIdx`. Index bits 11:5 of the hash pick the word and bits 4:0 pick the bit. An address that no slot matches is accepted exactly when it is multicast and its table bit is 1.
- R7: A unicast address (bit 0 equal to 0) that no valid slot matches is rejected, whatever the table holds.
- R8: The broadcast address (all 48 bits 1) is always accepted.
- R9: A lookup sampled with `lkValid` high at a clock edge produces `resValid` high for exactly one cycle after the second following edge. `resAccept` is 0 whenever `resValid` is 0.
- R10: A write is seen by lookups issued on the next cycle or later. A lookup issued in the same cycle as a write sees the state from before that write.
- R11: A write with `wrSel`=3 changes nothing.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Asynchronous active-low reset |
| wrEn | input | 1 | Register write strobe, one cycle per write |
| wrSel | input | 2 | Write target: 0 slots, 1 table words, 2 window selector, 3 none |
| wrIdx | input | 7 | Register index inside the chosen target |
| wrData | input | 32 | Write data |
| lkValid | input | 1 | Lookup request for the address on `lkAddr` |
| lkAddr | input | 48 | Destination address, byte 0 in bits 7:0 |
| resValid | output | 1 | Result pulse, two cycles after the request |
| resAccept | output | 1 | Accept (1) or reject (0), qualified by `resValid` |

## Verification
The latency and broadcast properties assume that `lkValid` and `lkAddr` are stable across the sampling edge, and that `lkValid` is held low while reset is asserted. The bench drives every input on the falling edge and keeps `lkValid` low during reset. The unicast-rejection property assumes that software may load any pattern into the table, so the bench sets table bits that alias unicast addresses and expects them to be ignored. Hash windows are swept across strided and edge indices for each selector value. This gives close to exhaustive coverage of word and bit positions.

// File: rtl/rxf_pkg.sv
package rxf_pkg;

  typedef enum logic [1:0] {
    SEL_EXACT = 2'd0,
    SEL_HASH  = 2'd1,
    SEL_TYPE  = 2'd2,
    SEL_NONE  = 2'd3
  } wrSel_e;

  typedef struct packed {
    logic exactLoWe;
    logic exactHiWe;
    logic hashWe;
    logic typeWe;
    logic lookupGo;
  } ctrlStrb_t;

endpackage

// File: rtl/rxf_ctrl.sv
module rxf_ctrl
  import rxf_pkg::*;
#(
  parameter int NUM_EXACT  = 16,
  parameter int HASH_WORDS = 128,
  parameter int WIDX_W     = 7
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              wrEn,
  input  logic [1:0]        wrSel,
  input  logic [WIDX_W-1:0] wrIdx,
  input  logic              lkValid,
  output ctrlStrb_t         strb,
  output logic              resValid
);

  localparam int EXACT_REGS = 2 * NUM_EXACT;

  logic inExact;
  logic inHash;
  logic stage1Valid;

  assign inExact = {1'b0, wrIdx} < (WIDX_W+1)'(EXACT_REGS);
  assign inHash  = {1'b0, wrIdx} < (WIDX_W+1)'(HASH_WORDS);

  always_comb begin
    strb = '0;
    if (wrEn) begin
      case (wrSel_e'(wrSel))
        SEL_EXACT: begin
          if (inExact) begin
            strb.exactLoWe = !wrIdx[0];
            strb.exactHiWe = wrIdx[0];
          end
        end
        SEL_HASH: strb.hashWe = inHash;
        SEL_TYPE: strb.typeWe = 1'b1;
        default:  ;
      endcase
    end
    strb.lookupGo = lkValid;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      stage1Valid <= 1'b0;
      resValid    <= 1'b0;
    end else begin
      stage1Valid <= lkValid;
      resValid    <= stage1Valid;
    end
  end

  AST_FIXED_LATENCY: assert property (@(posedge clk) disable iff (!rstN)
    lkValid |-> ##2 resValid); // R9

  AST_WRITE_DECODE: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({strb.exactLoWe, strb.exactHiWe, strb.hashWe, strb.typeWe})); // R2

endmodule

// File: rtl/rxf_datapath.sv
module rxf_datapath
  import rxf_pkg::*;
#(
  parameter int NUM_EXACT  = 16,
  parameter int HASH_WORDS = 128,
  parameter int WORD_W     = 32,
  parameter int ADDR_W     = 48,
  parameter int WIDX_W     = 7
) (
  input  logic              clk,
  input  logic              rstN,
  input  ctrlStrb_t         strb,
  input  logic [WIDX_W-1:0] wrIdx,
  input  logic [31:0]       wrData,
  input  logic [ADDR_W-1:0] lkAddr,
  output logic              resAccept
);

  localparam int ENTRY_W = $clog2(NUM_EXACT);
  localparam int WSEL_W  = $clog2(HASH_WORDS);
  localparam int BIT_W   = $clog2(WORD_W);
  localparam int HASH_W  = WSEL_W + BIT_W;
  localparam int LO_W    = 32;
  localparam int HI_W    = ADDR_W - LO_W;
  localparam int SH0     = ADDR_W - HASH_W;
  localparam int SH1     = SH0 - 1;
  localparam int SH2     = SH0 - 2;
  localparam int SH3     = SH0 - 4;

  logic [LO_W-1:0]      loReg [NUM_EXACT];
  logic [HI_W-1:0]      hiReg [NUM_EXACT];
  logic [NUM_EXACT-1:0] entValid;
  logic [NUM_EXACT-1:0] hitVec;
  logic [WORD_W-1:0]    mta [HASH_WORDS];
  logic [1:0]           fType;

  logic [ENTRY_W-1:0]   entIdx;
  logic [HASH_W-1:0]    hIdx;
  logic [WORD_W-1:0]    tblWord;
  logic                 tblBit;
  logic                 exactAny;
  logic                 isBcast;
  logic                 s1Go;
  logic                 s1Exact;
  logic                 s1Hash;
  logic                 s1Bcast;
  logic                 unusedBits;

  assign entIdx     = wrIdx[ENTRY_W:1];
  assign unusedBits = ^{wrData[30:HI_W]};

  // exact-match slots
  for (genvar g = 0; g < NUM_EXACT; g++) begin : gSlot
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        loReg[g]    <= '0;
        hiReg[g]    <= '0;
        entValid[g] <= 1'b0;
      end else begin
        if (strb.exactLoWe && entIdx == ENTRY_W'(g)) begin
          loReg[g] <= wrData[LO_W-1:0];
        end
        if (strb.exactHiWe && entIdx == ENTRY_W'(g)) begin
          hiReg[g]    <= wrData[HI_W-1:0];
          entValid[g] <= wrData[31];
        end
      end
    end
    assign hitVec[g] = entValid[g] && ({hiReg[g], loReg[g]} == lkAddr);
  end

  // multicast hash table words
  for (genvar w = 0; w < HASH_WORDS; w++) begin : gWord
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        mta[w] <= '0;
      end else if (strb.hashWe && wrIdx[WSEL_W-1:0] == WSEL_W'(w)) begin
        mta[w] <= wrData[WORD_W-1:0];
      end
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      fType <= 2'd0;
    end else if (strb.typeWe) begin
      fType <= wrData[1:0];
    end
  end

  // hash index window
  always_comb begin
    case (fType)
      2'd0:    hIdx = lkAddr[SH0 +: HASH_W];
      2'd1:    hIdx = lkAddr[SH1 +: HASH_W];
      2'd2:    hIdx = lkAddr[SH2 +: HASH_W];
      default: hIdx = lkAddr[SH3 +: HASH_W];
    endcase
  end

  assign tblWord  = mta[hIdx[HASH_W-1:BIT_W]];
  assign tblBit   = tblWord[hIdx[BIT_W-1:0]];
  assign exactAny = |hitVec;
  assign isBcast  = &lkAddr;

  // two-stage result pipeline
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      s1Go      <= 1'b0;
      s1Exact   <= 1'b0;
      s1Hash    <= 1'b0;
      s1Bcast   <= 1'b0;
      resAccept <= 1'b0;
    end else begin
      s1Go      <= strb.lookupGo;
      s1Exact   <= exactAny;
      s1Hash    <= lkAddr[0] & tblBit;
      s1Bcast   <= isBcast;
      resAccept <= s1Go & (s1Exact | s1Hash | s1Bcast);
    end
  end

  AST_BCAST_KEPT: assert property (@(posedge clk) disable iff (!rstN)
    strb.lookupGo && isBcast |-> ##2 resAccept); // R8

  AST_UNICAST_NO_HASH: assert property (@(posedge clk) disable iff (!rstN)
    strb.lookupGo && !lkAddr[0] && !exactAny |-> ##2 !resAccept); // R7

  AST_SLOT_HIT: assert property (@(posedge clk) disable iff (!rstN)
    strb.lookupGo && exactAny |-> ##2 resAccept); // R3

endmodule

// File: rtl/rx_addr_filter.sv
module rx_addr_filter
  import rxf_pkg::*;
#(
  parameter int NUM_EXACT  = 16,
  parameter int HASH_WORDS = 128,
  parameter int WORD_W     = 32,
  parameter int ADDR_W     = 48,
  localparam int WIDX_W    = ($clog2(HASH_WORDS) > $clog2(2*NUM_EXACT)) ?
                             $clog2(HASH_WORDS) : $clog2(2*NUM_EXACT)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              wrEn,
  input  logic [1:0]        wrSel,
  input  logic [WIDX_W-1:0] wrIdx,
  input  logic [31:0]       wrData,
  input  logic              lkValid,
  input  logic [ADDR_W-1:0] lkAddr,
  output logic              resValid,
  output logic              resAccept
);

  ctrlStrb_t strb;

  rxf_ctrl #(
    .NUM_EXACT (NUM_EXACT),
    .HASH_WORDS(HASH_WORDS),
    .WIDX_W    (WIDX_W)
  ) uCtrl (
    .clk     (clk),
    .rstN    (rstN),
    .wrEn    (wrEn),
    .wrSel   (wrSel),
    .wrIdx   (wrIdx),
    .lkValid (lkValid),
    .strb    (strb),
    .resValid(resValid)
  );

  rxf_datapath #(
    .NUM_EXACT (NUM_EXACT),
    .HASH_WORDS(HASH_WORDS),
    .WORD_W    (WORD_W),
    .ADDR_W    (ADDR_W),
    .WIDX_W    (WIDX_W)
  ) uDp (
    .clk      (clk),
    .rstN     (rstN),
    .strb     (strb),
    .wrIdx    (wrIdx),
    .wrData   (wrData),
    .lkAddr   (lkAddr),
    .resAccept(resAccept)
  );

  AST_ACCEPT_QUALIFIED: assert property (@(posedge clk) disable iff (!rstN)
    resAccept |-> resValid); // R9

endmodule

// File: tb/sim_rx_addr_filter.sv
`timescale 1ns/1ps
module sim_rx_addr_filter;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        wrEn = 1'b0;
  logic [1:0]  wrSel = 2'd0;
  logic [6:0]  wrIdx = 7'd0;
  logic [31:0] wrData = 32'd0;
  logic        lkValid = 1'b0;
  logic [47:0] lkAddr = 48'd0;
  logic        resValid;
  logic        resAccept;

  int nChecks = 0;
  int nErrors = 0;
  bit summaryDone = 1'b0;

  // reference state
  logic [31:0] mLo [16];
  logic [15:0] mHi [16];
  logic        mV  [16];
  logic [31:0] mTbl [128];
  logic [1:0]  mType;

  localparam logic [47:0] UADDR = 48'hA1B2_C3D4_E5F0;

  always #2.5 clk = ~clk;

  rx_addr_filter u0 (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .wrSel(wrSel), .wrIdx(wrIdx),
    .wrData(wrData), .lkValid(lkValid), .lkAddr(lkAddr),
    .resValid(resValid), .resAccept(resAccept)
  );

  function automatic int shiftOf(logic [1:0] t);
    case (t)
      2'd0: return 36;
      2'd1: return 35;
      2'd2: return 34;
      default: return 32;
    endcase
  endfunction

  function automatic logic expAccept(logic [47:0] a);
    logic [11:0] hidx;
    if (&a) return 1'b1;
    for (int n = 0; n < 16; n++)
      if (mV[n] && {mHi[n], mLo[n]} == a) return 1'b1;
    if (!a[0]) return 1'b0;
    hidx = 12'((a >> shiftOf(mType)) & 48'hFFF);
    return mTbl[hidx[11:5]][hidx[4:0]];
  endfunction

  function automatic void modelWrite(logic [1:0] s, logic [6:0] i, logic [31:0] d);
    case (s)
      2'd0: if (i < 7'd32) begin
        if (!i[0]) mLo[i[4:1]] = d;
        else begin mHi[i[4:1]] = d[15:0]; mV[i[4:1]] = d[31]; end
      end
      2'd1: mTbl[i] = d;
      2'd2: mType = d[1:0];
      default: ;
    endcase
  endfunction

  function automatic logic [47:0] mkAddr(logic [1:0] t, logic [11:0] idx);
    logic [47:0] a;
    int sh;
    sh = shiftOf(t);
    a = 48'h9C3B_6A52_47E1;
    a = a & ~(48'hFFF << sh);
    a = a | (48'(idx) << sh);
    return a;
  endfunction

  task automatic check(string tag, logic act, logic exp);
    nChecks++;
    if (act !== exp) begin
      nErrors++;
      $display("FAIL %s: actual=%0b expected=%0b", tag, act, exp);
    end
  endtask

  // called at a falling edge; returns at a falling edge
  task automatic wr(logic [1:0] s, logic [6:0] i, logic [31:0] d);
    wrEn = 1'b1; wrSel = s; wrIdx = i; wrData = d;
    modelWrite(s, i, d);
    @(negedge clk);
    wrEn = 1'b0;
  endtask

  task automatic look(logic [47:0] a, string tag);
    logic e;
    e = expAccept(a);
    lkValid = 1'b1; lkAddr = a;
    @(negedge clk);
    lkValid = 1'b0;
    check({tag, " R9 no early result"}, resValid, 1'b0);
    @(negedge clk);
    check({tag, " R9 result valid"}, resValid, 1'b1);
    check(tag, resAccept, e);
  endtask

  task automatic finishRun();
    if (!summaryDone) begin
      summaryDone = 1'b1;
      $display("Result: errors=%0d of %0d checks", nErrors, nChecks);
      $finish;
    end
  endtask

  initial begin
    #(5.0 * 150000);
    nChecks++;
    nErrors++;
    $display("FAIL watchdog: actual=timeout expected=done");
    finishRun();
  end

  initial begin
    for (int n = 0; n < 16; n++) begin mLo[n] = '0; mHi[n] = '0; mV[n] = 1'b0; end
    for (int w = 0; w < 128; w++) mTbl[w] = '0;
    mType = 2'd0;

    repeat (4) @(negedge clk);
    check("R1 reset resValid", resValid, 1'b0);
    check("R1 reset resAccept", resAccept, 1'b0);
    rstN = 1'b1;
    @(negedge clk);

    // R1 empty state, R8 broadcast
    look(48'h0000_0000_0001, "R1 empty mc reject");
    look(48'hFFFF_FFFF_FFFD, "R1 empty near-bcast reject");
    look(UADDR, "R1 empty unicast reject");
    look(48'hFFFF_FFFF_FFFF, "R8 broadcast accept");
    @(negedge clk);
    check("R9 single-cycle pulse", resValid, 1'b0);

    // R1 default selector is 0: set bit for type-0 index
    begin
      logic [47:0] a;
      a = mkAddr(2'd0, 12'h5A7);
      wr(2'd1, 7'(12'h5A7 >> 5), 32'h1 << (12'h5A7 & 31));
      look(a, "R1 default type0 hash accept");
      check("R1 default type0 model", expAccept(a), 1'b1);
      wr(2'd1, 7'(12'h5A7 >> 5), 32'h0);
      look(a, "R6 cleared word reject");
    end

    // R2 layout with junk in ignored bits, R3 exact match
    wr(2'd0, 7'd0, UADDR[31:0]);
    wr(2'd0, 7'd1, {1'b1, 15'h7FFF, UADDR[47:32]});
    look(UADDR, "R2 slot0 accept");
    for (int b = 0; b < 48; b++)
      look(UADDR ^ (48'h1 << b), $sformatf("R3 bit %0d flip reject", b));

    // R3 all slots
    for (int n = 1; n < 16; n++) begin
      wr(2'd0, 7'(2*n), 32'h1000_0000 + 32'(n * 32'h0101_0102));
      wr(2'd0, 7'(2*n+1), 32'h8000_0200 + 32'(n));
    end
    for (int n = 0; n < 16; n++)
      look({mHi[n], mLo[n]}, $sformatf("R3 slot %0d accept", n));

    // R4 valid flag
    begin
      logic [47:0] a5;
      a5 = {mHi[5], mLo[5]};
      wr(2'd0, 7'd11, 32'h0);
      look(a5, "R4 cleared high reject");
      wr(2'd0, 7'd11, {1'b0, 15'h0, a5[47:32]});
      look(a5, "R4 invalid with data reject");
      wr(2'd0, 7'd11, {1'b1, 15'h0, a5[47:32]});
      look(a5, "R4 re-enabled accept");
      wr(2'd0, 7'd10, 32'hDEAD_BEE0);
      look(a5, "R2 old low word reject");
      look({a5[47:32], 32'hDEAD_BEE0}, "R2 new low word accept");
    end

    // R10 same-cycle write sees old state, next cycle sees new
    begin
      logic [47:0] a7;
      logic e;
      a7 = {mHi[7], mLo[7]};
      e = expAccept(a7);
      wrEn = 1'b1; wrSel = 2'd0; wrIdx = 7'd15; wrData = 32'h0;
      lkValid = 1'b1; lkAddr = a7;
      modelWrite(2'd0, 7'd15, 32'h0);
      @(negedge clk);
      wrEn = 1'b0; lkValid = 1'b0;
      @(negedge clk);
      check("R10 same-cycle valid", resValid, 1'b1);
      check("R10 same-cycle sees old", resAccept, e);
      check("R10 old value was accept", e, 1'b1);
      look(a7, "R10 later lookup sees disable");
    end

    // R11 sel 3, R2 out-of-range slot index
    wr(2'd3, 7'd1, 32'h0);
    wr(2'd3, 7'd0, 32'h0);
    look(UADDR, "R11 sel3 no effect");
    wr(2'd0, 7'd33, 32'h0);
    wr(2'd0, 7'd32, 32'h0);
    look(UADDR, "R2 index above range ignored");

    // R5/R6/R7 hash sweep per selector
    for (int t = 0; t < 4; t++) begin
      wr(2'd2, 7'd0, 32'hFFFF_FFFC | 32'(t));
      for (int k = 0; k < 114; k++) begin
        logic [11:0] idx;
        logic [47:0] a;
        idx = (k == 113) ? 12'hFFF : 12'((k * 37 + t * 5) % 4096);
        a = mkAddr(2'(t), idx);
        wr(2'd1, 7'(idx >> 5), 32'h1 << idx[4:0]);
        look(a, $sformatf("R5 R6 type %0d idx %0d accept", t, idx));
        look(mkAddr(2'(t), idx ^ 12'h021), $sformatf("R6 type %0d neighbour of %0d", t, idx));
        look(a & ~48'h1, $sformatf("R7 type %0d idx %0d unicast reject", t, idx));
        wr(2'd1, 7'(idx >> 5), 32'h0);
      end
    end

    // R5 window selection: bit set for type 3 index, lookups under other types
    begin
      logic [47:0] a;
      a = mkAddr(2'd3, 12'h2C9);
      wr(2'd1, 7'(12'h2C9 >> 5), 32'h1 << 5'(12'h2C9 & 31));
      for (int t = 0; t < 4; t++) begin
        wr(2'd2, 7'd0, 32'(t));
        look(a, $sformatf("R5 selector %0d on type3 address", t));
      end
    end

    finishRun();
  end

endmodule